// File: doc/BRIEF.md
# Hardware Error Recovery Sequencer

This block steers a processor through recovery once an error detector has fired. It stops the machine first. It then asks the store-queue logic to push all pending store data out to the second-level cache and waits for that to finish. Next it pulses a reset to the functional units for a fixed number of cycles. Last, it runs two check passes over the register named by the error report. Each pass reads a SECDED-protected word from the register file, decodes it, and writes back the repaired word when the decoder finds a single flipped bit.

If the word is still uncorrectable after the second pass, the sequencer raises a sticky fatal flag and keeps the machine halted until reset. Otherwise it signals completion for one cycle and releases the halt. Error reports that arrive while a recovery is in progress are dropped.

The register file, the store queue and the cache sit outside the block. The sequencer only drives their handshakes and the register read/write port.

Top module: `err_recovery_seq`

## Requirements
- R1: After reset, every output is low: halt, drain request, unit reset, read enable, write enable, done and fatal.
- R2: When err_i is high in the idle state, halt_o rises one cycle later. It stays high through the whole recovery and is low only in the idle state.
- R3: drain_req_o rises in the cycle after halt_o rises. It stays high until drain_done_i is sampled high on a clock edge.
- R4: unit_rst_o goes high in the cycle after drain_done_i is accepted. It stays high for exactly RST_CYCLES (default 4) consecutive cycles and is never high before the drain is acknowledged.
- R5: In a check pass, rf_rd_en_o is high and rf_addr_o carries the register index captured with the error. If the word holds a single-bit error, rf_wr_en_o is high in that same cycle and rf_wdata_o carries the word with the faulty bit inverted.
- R6: The 39-bit code word is laid out as follows.
  - Bit 0 is an overall parity bit, chosen so the XOR of all 39 bits is 0.
  - Bits 1, 2, 4, 8, 16 and 32 are Hamming check bits.
  - Data bits 0 to 31 fill the remaining positions 3 to 38 in ascending order.
  - The syndrome is the XOR of the positions of all set bits among 1 to 38.
  - Odd overall parity with a syndrome of 38 or less is a single error at that position, where syndrome 0 means bit 0.
  - Even parity with a non-zero syndrome, or odd parity with a syndrome above 38, is uncorrectable.
- R7: There are exactly two check passes, in consecutive cycles right after unit reset ends. The second pass reads the register again, so it sees any repair made by the first.
- R8: If the second pass finds an uncorrectable word, fatal_o rises in the next cycle. fatal_o and halt_o then stay high until reset, and done_o never pulses.
- R9: Otherwise done_o is high for exactly one cycle after the second pass, and halt_o falls in the following cycle.
- R10: err_i and err_reg_i are ignored while a recovery is in progress. The timing and the register index of that recovery do not change.
- R11: A word that decodes clean (zero syndrome, even parity) is never written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | 1 | Error detector fired |
| err_reg_i | input | REG_AW | Register index affected by the error |
| halt_o | output | 1 | Stop execution |
| drain_req_o | output | 1 | Request to flush queued stores to the second-level cache |
| drain_done_i | input | 1 | Flush finished |
| unit_rst_o | output | 1 | Reset strobe to the functional units |
| rf_rd_en_o | output | 1 | Register-file read in a check pass |
| rf_addr_o | output | REG_AW | Register index for read and write |
| rf_rdata_i | input | CW_W | Code word read from the register file (combinational) |
| rf_wr_en_o | output | 1 | Write back the repaired word |
| rf_wdata_o | output | CW_W | Repaired code word |
| done_o | output | 1 | Recovery finished, execution may resume |
| fatal_o | output | 1 | Unrecoverable error, sticky until reset |

## Verification
The properties assume three things about the environment. The register file returns the addressed word in the same cycle without delay. drain_done_i is only meaningful while a drain is requested. The register file commits a write at the clock edge that ends the pass. The bench supplies all three: its register model reads combinationally and commits writes on the edge, and its drain responder raises the acknowledgement only while it sees the request, then drops it after one cycle. Error reports are pulsed or held deliberately inside an active recovery, so the assertions on captured index and sequence order are exercised without ever leaving the handshakes undefined.

// File: rtl/rec_pkg.sv
package rec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_DRAIN,
        ST_RESET,
        ST_PASS1,
        ST_PASS2,
        ST_DONE,
        ST_FATAL
    } rec_state_e;

    // Smallest Hamming check-bit count r with 2**r >= data + r + 1.
    function automatic int chk_bits(input int data_w);
        int r;
        r = 1;
        while ((1 << r) < data_w + r + 1) r++;
        return r;
    endfunction

endpackage

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 32,
    localparam int CHK_W = rec_pkg::chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic [CW_W-1:0] cw_i,
    output logic            err_single_o,
    output logic            err_multi_o,
    output logic [CW_W-1:0] cw_fix_o
);

    logic [CHK_W-1:0] syn;
    logic             par;
    logic             in_range;

    // Syndrome is the XOR of the positions of all set bits above bit 0.
    always_comb begin
        syn = '0;
        for (int i = 1; i < CW_W; i++) begin
            if (cw_i[i]) syn = syn ^ i[CHK_W-1:0];
        end
    end

    assign par          = ^cw_i;
    assign in_range     = int'(syn) < CW_W;
    assign err_single_o = par && in_range;
    assign err_multi_o  = (!par && (syn != '0)) || (par && !in_range);

    // Invert the bit the syndrome points at; syndrome 0 points at the parity bit.
    always_comb begin
        cw_fix_o = cw_i;
        for (int i = 0; i < CW_W; i++) begin
            if (err_single_o && (syn == i[CHK_W-1:0])) cw_fix_o[i] = ~cw_i[i];
        end
    end

endmodule

// File: rtl/unit_rst_timer.sv
module unit_rst_timer #(
    parameter int CYCLES = 4,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o,
    output logic last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = cnt_q != '0;
    assign last_o   = cnt_q == CNT_W'(1);

endmodule

// File: rtl/err_recovery_seq.sv
module err_recovery_seq #(
    parameter int DATA_W     = 32,
    parameter int REG_AW     = 5,
    parameter int RST_CYCLES = 4,
    localparam int CHK_W = rec_pkg::chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic [REG_AW-1:0] err_reg_i,
    output logic              halt_o,
    output logic              drain_req_o,
    input  logic              drain_done_i,
    output logic              unit_rst_o,
    output logic              rf_rd_en_o,
    output logic [REG_AW-1:0] rf_addr_o,
    input  logic [CW_W-1:0]   rf_rdata_i,
    output logic              rf_wr_en_o,
    output logic [CW_W-1:0]   rf_wdata_o,
    output logic              done_o,
    output logic              fatal_o
);
    import rec_pkg::*;

    typedef struct packed {
        rec_state_e        st;
        logic [REG_AW-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    logic tmr_start, tmr_active, tmr_last;
    logic dec_single, dec_multi;
    logic [CW_W-1:0] dec_fix;

    unit_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .active_o (tmr_active),
        .last_o   (tmr_last)
    );

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .cw_i         (rf_rdata_i),
        .err_single_o (dec_single),
        .err_multi_o  (dec_multi),
        .cw_fix_o     (dec_fix)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_start = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (err_i) begin
                    seq_d.st  = ST_HALT;
                    seq_d.idx = err_reg_i;
                end
            end
            ST_HALT:  seq_d.st = ST_DRAIN;
            ST_DRAIN: begin
                if (drain_done_i) begin
                    seq_d.st  = ST_RESET;
                    tmr_start = 1'b1;
                end
            end
            ST_RESET: if (tmr_last) seq_d.st = ST_PASS1;
            ST_PASS1: seq_d.st = ST_PASS2;
            ST_PASS2: seq_d.st = dec_multi ? ST_FATAL : ST_DONE;
            ST_DONE:  seq_d.st = ST_IDLE;
            ST_FATAL: seq_d.st = ST_FATAL;
            default:  seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st  <= ST_IDLE;
            seq_q.idx <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign halt_o      = seq_q.st != ST_IDLE;
    assign drain_req_o = seq_q.st == ST_DRAIN;
    assign unit_rst_o  = tmr_active;
    assign rf_rd_en_o  = (seq_q.st == ST_PASS1) || (seq_q.st == ST_PASS2);
    assign rf_addr_o   = seq_q.idx;
    assign rf_wr_en_o  = rf_rd_en_o && dec_single;
    assign rf_wdata_o  = dec_fix;
    assign done_o      = seq_q.st == ST_DONE;
    assign fatal_o     = seq_q.st == ST_FATAL;

endmodule

// File: rtl/rec_seq_chk.sv
module rec_seq_chk #(
    parameter int REG_AW     = 5,
    parameter int RST_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_i,
    input logic [REG_AW-1:0] err_reg_i,
    input logic              halt_o,
    input logic              drain_req_o,
    input logic              drain_done_i,
    input logic              unit_rst_o,
    input logic              rf_rd_en_o,
    input logic [REG_AW-1:0] rf_addr_o,
    input logic              rf_wr_en_o,
    input logic              done_o,
    input logic              fatal_o
);
    localparam int RUN_W = $clog2(RST_CYCLES + 2);

    logic [RUN_W-1:0]  run_q;
    logic [REG_AW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (unit_rst_o) run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                held_q <= '0;
        else if (!halt_o && err_i) held_q <= err_reg_i;
    end

    assert_halt_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req_o || unit_rst_o || rf_rd_en_o || done_o || fatal_o) |-> halt_o);
    assert_halt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> $past(err_i));
    assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req_o && !drain_done_i) |=> drain_req_o);
    assert_rst_after_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unit_rst_o) |-> $past(drain_req_o && drain_done_i));
    assert_rst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unit_rst_o) |-> (int'(run_q) == RST_CYCLES));
    assert_rst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst_o |-> (int'(run_q) < RST_CYCLES));
    assert_wr_in_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> (rf_rd_en_o && !unit_rst_o));
    assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> (fatal_o && halt_o && !done_o));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !halt_o));
    assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en_o |-> (rf_addr_o == held_q));
    assert_phase_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req_o, unit_rst_o, rf_rd_en_o, done_o, fatal_o}));

endmodule

bind err_recovery_seq rec_seq_chk #(.REG_AW(REG_AW), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_i        (err_i),
    .err_reg_i    (err_reg_i),
    .halt_o       (halt_o),
    .drain_req_o  (drain_req_o),
    .drain_done_i (drain_done_i),
    .unit_rst_o   (unit_rst_o),
    .rf_rd_en_o   (rf_rd_en_o),
    .rf_addr_o    (rf_addr_o),
    .rf_wr_en_o   (rf_wr_en_o),
    .done_o       (done_o),
    .fatal_o      (fatal_o)
);

// File: tb/err_recovery_seq_bench.sv
module err_recovery_seq_bench;
    localparam int AW = 5;
    localparam int CW = 39;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_i = 1'b0;
    logic [AW-1:0] err_reg_i = '0;
    logic drain_done_i = 1'b0;
    logic halt_o, drain_req_o, unit_rst_o, rf_rd_en_o, rf_wr_en_o, done_o, fatal_o;
    logic [AW-1:0] rf_addr_o;
    logic [CW-1:0] rf_rdata_i, rf_wdata_o;

    logic [CW-1:0] mem [0:31];
    int n_chk = 0, n_bad = 0, cyc = 0, drain_delay = 0, dcnt = 0, wr_count = 0;
    int m = 0, mcnt = 0, midx = 0;
    bit seen_done, seen_fatal;

    always #4 clk = ~clk;

    assign rf_rdata_i = mem[rf_addr_o];

    err_recovery_seq u_err_recovery_seq (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .err_reg_i(err_reg_i),
        .halt_o(halt_o), .drain_req_o(drain_req_o), .drain_done_i(drain_done_i),
        .unit_rst_o(unit_rst_o), .rf_rd_en_o(rf_rd_en_o), .rf_addr_o(rf_addr_o),
        .rf_rdata_i(rf_rdata_i), .rf_wr_en_o(rf_wr_en_o), .rf_wdata_o(rf_wdata_o),
        .done_o(done_o), .fatal_o(fatal_o)
    );

    function automatic logic [CW-1:0] enc(input logic [31:0] d);
        logic [CW-1:0] w;
        int k;
        w = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 6; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW; p++) begin
                if (((p >> b) & 1) == 1 && p != (1 << b)) x = x ^ w[p];
            end
            w[1 << b] = x;
        end
        w[0] = ^w[CW-1:1];
        return w;
    endfunction

    function automatic int bsyn(input logic [CW-1:0] w);
        int s;
        s = 0;
        for (int p = 1; p < CW; p++) if (w[p]) s = s ^ p;
        return s;
    endfunction

    function automatic bit fixable(input logic [CW-1:0] w);
        return (^w) && (bsyn(w) < CW);
    endfunction

    function automatic bit broken(input logic [CW-1:0] w);
        return (!(^w) && bsyn(w) != 0) || ((^w) && bsyn(w) >= CW);
    endfunction

    function automatic logic [CW-1:0] repaired(input logic [CW-1:0] w);
        logic [CW-1:0] r;
        r = w;
        r[bsyn(w)] = ~r[bsyn(w)];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model plus register-file write port, stepped on every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m = 0;
            mcnt = 0;
        end else begin
            case (m)
                0: if (err_i) begin m = 1; midx = int'(err_reg_i); end
                1: m = 2;
                2: if (drain_done_i) begin m = 3; mcnt = 0; end
                3: begin mcnt++; if (mcnt == 4) m = 4; end
                4: m = 5;
                5: m = broken(mem[midx]) ? 7 : 6;
                6: m = 0;
                default: m = 7;
            endcase
            if (rf_wr_en_o) begin
                mem[rf_addr_o] = rf_wdata_o;
                wr_count++;
            end
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Drain responder: acknowledges after drain_delay cycles of request.
    always @(negedge clk) begin
        drain_done_i = 1'b0;
        if (drain_req_o) begin
            if (dcnt >= drain_delay) begin
                drain_done_i = 1'b1;
                dcnt = 0;
            end else dcnt++;
        end else dcnt = 0;
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit pass_x, wr_x;
            pass_x = (m == 4) || (m == 5);
            wr_x   = pass_x && fixable(mem[midx]);
            chk("R2 halt", 64'(halt_o), 64'(m != 0));
            chk("R3 drain_req", 64'(drain_req_o), 64'(m == 2));
            chk("R4 unit_rst", 64'(unit_rst_o), 64'(m == 3));
            chk("R7 rd_en", 64'(rf_rd_en_o), 64'(pass_x));
            if (pass_x) chk("R10 addr", 64'(rf_addr_o), 64'(midx));
            chk("R5 wr_en", 64'(rf_wr_en_o), 64'(wr_x));
            if (wr_x) chk("R6 wdata", 64'(rf_wdata_o), 64'(repaired(mem[midx])));
            chk("R9 done", 64'(done_o), 64'(m == 6));
            chk("R8 fatal", 64'(fatal_o), 64'(m == 7));
            if (done_o) seen_done = 1'b1;
            if (fatal_o) seen_fatal = 1'b1;
        end
    end

    task automatic recover(input int idx, input logic [CW-1:0] word, input int dly,
                           input bit noise);
        @(negedge clk);
        mem[idx] = word;
        drain_delay = dly;
        seen_done = 1'b0;
        seen_fatal = 1'b0;
        wr_count = 0;
        err_i = 1'b1;
        err_reg_i = AW'(idx);
        @(negedge clk);
        err_i = 1'b0;
        if (noise) begin
            // R10: a second report with another index during recovery
            @(negedge clk);
            err_i = 1'b1;
            err_reg_i = AW'(idx + 1);
            repeat (6) @(negedge clk);
            err_i = 1'b0;
        end
        for (int i = 0; i < 300; i++) begin
            if (seen_done || seen_fatal) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [CW-1:0] a;
        a = enc(32'hDEAD_BEEF);
        for (int i = 0; i < 32; i++) mem[i] = enc(32'(i * 32'h0101_0101));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle outputs", 64'({halt_o, drain_req_o, unit_rst_o, rf_rd_en_o,
                                    rf_wr_en_o, done_o, fatal_o}), 64'd0);

        recover(3, a, 0, 1'b0);
        chk("R11 clean no write", 64'(wr_count), 64'd0);
        chk("R9 clean done", 64'(seen_done), 64'd1);
        chk("R11 clean word kept", 64'(mem[3]), 64'(a));

        recover(7, a ^ (39'd1 << 13), 3, 1'b0);
        chk("R5 one repair write", 64'(wr_count), 64'd1);
        chk("R5 data bit repaired", 64'(mem[7]), 64'(a));

        recover(9, a ^ 39'd1, 1, 1'b0);
        chk("R6 parity bit repaired", 64'(mem[9]), 64'(a));

        recover(11, a ^ (39'd1 << 8), 0, 1'b1);
        chk("R6 check bit repaired", 64'(mem[11]), 64'(a));
        chk("R10 neighbour untouched", 64'(mem[12]), 64'(enc(32'(12 * 32'h0101_0101))));
        chk("R9 done after noise", 64'(seen_done), 64'd1);

        recover(14, a ^ (39'd1 << 5) ^ (39'd1 << 20), 2, 1'b0);
        chk("R8 double fatal", 64'(seen_fatal), 64'd1);
        chk("R8 no done", 64'(seen_done), 64'd0);
        chk("R7 double not written", 64'(wr_count), 64'd0);
        err_i = 1'b1;
        repeat (8) @(negedge clk);
        err_i = 1'b0;
        chk("R8 fatal sticky", 64'({fatal_o, halt_o}), 64'd3);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'({halt_o, fatal_o, done_o}), 64'd0);

        recover(20, a ^ (39'd1 << 32) ^ (39'd1 << 15) ^ (39'd1 << 8), 0, 1'b0);
        chk("R6 out-of-range syndrome fatal", 64'(seen_fatal), 64'd1);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        recover(1, a ^ (39'd1 << 38), 4, 1'b0);
        chk("R5 top bit repaired", 64'(mem[1]), 64'(a));
        chk("R2 halt released", 64'(halt_o), 64'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule